// File: doc/BRIEF.md
# Byte-Wide Flash Read Path with Write Status

This block forms the byte returned on the data pins of a byte-wide flash memory during a read. On every clock it picks one of three sources: the byte stored in the array at the current address, a fixed identification byte while identification mode is active, or a status byte while an internal program or erase operation runs. The tri-state enable it produces lets the pad ring drive the data pins only when the host has selected the device and enabled its outputs.

During a program or erase operation the host polls for completion in two ways. Reading the address it last wrote returns bit 7 inverted until the operation ends. Any read returns bit 6 from a toggle flop that changes state at the end of each read, so two reads in a row differ while the device is busy and match once it is idle. The block keeps this toggle flop. The program and erase timers that drive `busy` lie outside this block, as does the array storage.

Outputs are registered. A read sampled on one clock edge shows its result after that edge. Inputs are synchronous to `clk`.

Top module: `flash_rd_path`

## Requirements
- R1: `rd_oe` is 1 after a clock edge at which `ce_n` and `oe_n` were both sampled 0. After any other edge it is 0, and `rd_data` is then 00h.
- R2: After a clock edge with `rst` high, `rd_oe` is 0, `rd_data` is 00h and the toggle flop holds 0.
- R3: During a read with `busy` high at an address equal to `last_addr`, bit 7 of `rd_data` is the inverse of bit 7 of `last_data`.
- R4: During a read with `busy` high, bits 5 to 0 of `rd_data` are 0. Bit 7 is 0 when the address differs from `last_addr`.
- R5: During a read with `busy` high, bit 6 of `rd_data` equals the toggle flop. The flop inverts at each edge where `oe_n` is sampled 1 after being sampled 0 at the previous edge, provided `busy` is 1 and `ce_n` is 0 at that edge.
- R6: While `busy` is 0 the toggle flop keeps its value through any activity on `oe_n`. When `busy` rises again, the flop continues from the held value.
- R7: During a read with `busy` 0 and `id_mode` 1, address 0000h returns DAh, address 0001h returns C8h and every other address returns 00h.
- R8: During a read with `busy` 0 and `id_mode` 0, `rd_data` equals `arr_data` sampled at the same edge.
- R9: `busy` takes priority over `id_mode`. When both are 1, the read returns the status byte.
- R10: A rising edge of `oe_n` while `ce_n` is 1 does not change the toggle flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 16 | Read address |
| busy | input | 1 | Internal program or erase operation in progress |
| id_mode | input | 1 | Identification mode active |
| last_addr | input | 16 | Address of the last byte loaded |
| last_data | input | 8 | Value of the last byte loaded |
| arr_data | input | 8 | Array byte at `addr` |
| rd_data | output | 8 | Byte presented to the data pins |
| rd_oe | output | 1 | Enable for the tri-state data pins |

## Verification
A read and a toggle update can fall in the same cycle. The status byte is formed from the toggle value held before that edge, while the flop advances at the end of the read. The bench reads the busy device several times in a row and predicts each bit 6 from its own model of the toggle. It also raises `oe_n` with the chip deselected, and raises it while idle, then checks that the next busy read shows the unchanged value. Status and identification can also be requested together. Reads with `busy` and `id_mode` both high must return the status byte and never an identification code.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    localparam int BYTE_W   = 8;
    localparam int POLL_BIT = BYTE_W - 1;
    localparam int TGL_BIT  = BYTE_W - 2;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_IDENT  = 2'd2,
        SRC_STATUS = 2'd3
    } rd_src_e;

    typedef struct packed {
        logic              drive;
        logic [BYTE_W-1:0] data;
    } rd_beat_t;

    // Source priority: no read, then status, then identification, then array.
    function automatic rd_src_e pick_src(input logic rd, input logic bsy, input logic idm);
        if (!rd)      return SRC_NONE;
        else if (bsy) return SRC_STATUS;
        else if (idm) return SRC_IDENT;
        else          return SRC_ARRAY;
    endfunction

endpackage

// File: rtl/frp_toggle.sv
module frp_toggle (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic oe_n,
    input  logic busy,
    output logic tgl
);
    logic oe_n_q;
    logic tgl_q;
    logic read_end;

    assign read_end = oe_n && !oe_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_n_q <= 1'b1;
            tgl_q  <= 1'b0;
        end else begin
            oe_n_q <= oe_n;
            if (busy && !ce_n && read_end)
                tgl_q <= !tgl_q;
        end
    end

    assign tgl = tgl_q;
endmodule

// File: rtl/frp_select.sv
module frp_select
    import flash_rd_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [BYTE_W-1:0] MFR_CODE = 8'hDA,
    parameter logic [BYTE_W-1:0] DEV_CODE = 8'hC8
) (
    input  rd_src_e           src,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [BYTE_W-1:0] last_data,
    input  logic [BYTE_W-1:0] arr_data,
    input  logic              tgl,
    output logic [BYTE_W-1:0] byte_out
);
    localparam logic [ADDR_W-1:0] ID_MFR_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ID_DEV_ADDR = ADDR_W'(1);

    logic [BYTE_W-1:0] status_byte;
    logic [BYTE_W-1:0] ident_byte;

    always_comb begin
        status_byte           = '0;
        status_byte[POLL_BIT] = (addr == last_addr) ? !last_data[POLL_BIT] : 1'b0;
        status_byte[TGL_BIT]  = tgl;
    end

    always_comb begin
        if (addr == ID_MFR_ADDR)      ident_byte = MFR_CODE;
        else if (addr == ID_DEV_ADDR) ident_byte = DEV_CODE;
        else                          ident_byte = '0;
    end

    always_comb begin
        unique case (src)
            SRC_STATUS: byte_out = status_byte;
            SRC_IDENT:  byte_out = ident_byte;
            SRC_ARRAY:  byte_out = arr_data;
            default:    byte_out = '0;
        endcase
    end
endmodule

// File: rtl/flash_rd_path.sv
module flash_rd_path
    import flash_rd_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [BYTE_W-1:0] MFR_CODE = 8'hDA,
    parameter logic [BYTE_W-1:0] DEV_CODE = 8'hC8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [BYTE_W-1:0] last_data,
    input  logic [BYTE_W-1:0] arr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_oe
);
    logic              rd_req;
    rd_src_e           src;
    logic              tgl_bit;
    logic [BYTE_W-1:0] sel_byte;
    rd_beat_t          beat_d;
    rd_beat_t          beat_q;

    assign rd_req = !ce_n && !oe_n;
    assign src    = pick_src(rd_req, busy, id_mode);

    frp_toggle u_tgl (
        .clk  (clk),
        .rst  (rst),
        .ce_n (ce_n),
        .oe_n (oe_n),
        .busy (busy),
        .tgl  (tgl_bit)
    );

    frp_select #(
        .ADDR_W   (ADDR_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_sel (
        .src       (src),
        .addr      (addr),
        .last_addr (last_addr),
        .last_data (last_data),
        .arr_data  (arr_data),
        .tgl       (tgl_bit),
        .byte_out  (sel_byte)
    );

    always_comb begin
        beat_d.drive = rd_req;
        beat_d.data  = sel_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else     beat_q <= beat_d;
    end

    assign rd_data = beat_q.data;
    assign rd_oe   = beat_q.drive;
endmodule

// File: rtl/flash_rd_path_chk.sv
module flash_rd_path_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic              busy,
    input logic              id_mode,
    input logic [ADDR_W-1:0] last_addr,
    input logic [7:0]        last_data,
    input logic [7:0]        arr_data,
    input logic [7:0]        rd_data,
    input logic              rd_oe,
    input logic              tgl
);
    AST_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n) |=> rd_oe); // R1
    AST_HIZ_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |=> (!rd_oe && rd_data == 8'h00)); // R1
    AST_POLL_INVERTED: assert property (@(posedge clk) disable iff (rst)
        (busy && !ce_n && !oe_n && addr == last_addr) |=> (rd_data[7] == !$past(last_data[7]))); // R3
    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (busy && !ce_n && !oe_n) |=> (rd_data[5:0] == 6'd0)); // R4
    AST_STATUS_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (busy && !ce_n && !oe_n) |=> (rd_data[6] == $past(tgl))); // R5
    AST_TOGGLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!busy) |=> $stable(tgl)); // R6
    AST_ID_MFR: assert property (@(posedge clk) disable iff (rst)
        (!busy && id_mode && !ce_n && !oe_n && addr == ADDR_W'(0)) |=> (rd_data == 8'hDA)); // R7
    AST_ID_DEV: assert property (@(posedge clk) disable iff (rst)
        (!busy && id_mode && !ce_n && !oe_n && addr == ADDR_W'(1)) |=> (rd_data == 8'hC8)); // R7
    AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !id_mode && !ce_n && !oe_n) |=> (rd_data == $past(arr_data))); // R8
    AST_DESELECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ce_n) |=> $stable(tgl)); // R10
endmodule

bind flash_rd_path flash_rd_path_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .addr      (addr),
    .busy      (busy),
    .id_mode   (id_mode),
    .last_addr (last_addr),
    .last_data (last_data),
    .arr_data  (arr_data),
    .rd_data   (rd_data),
    .rd_oe     (rd_oe),
    .tgl       (tgl_bit)
);

// File: tb/flash_rd_path_bench.sv
`timescale 1ns/1ps
module flash_rd_path_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [15:0] addr = '0;
    logic        busy = 1'b0;
    logic        id_mode = 1'b0;
    logic [15:0] last_addr = '0;
    logic [7:0]  last_data = '0;
    logic [7:0]  arr_data = '0;
    logic [7:0]  rd_data;
    logic        rd_oe;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic tgl_m = 1'b0;

    always #2.5 clk = ~clk;

    flash_rd_path u_flash_rd_path (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
        .busy(busy), .id_mode(id_mode), .last_addr(last_addr),
        .last_data(last_data), .arr_data(arr_data),
        .rd_data(rd_data), .rd_oe(rd_oe)
    );

    function automatic logic [7:0] exp_byte(input logic b, input logic idm, input logic [15:0] a,
                                            input logic [15:0] la, input logic [7:0] ld,
                                            input logic [7:0] ad, input logic t);
        logic [7:0] r;
        if (b) begin
            r = 8'h00;
            r[7] = (a == la) ? ~ld[7] : 1'b0;
            r[6] = t;
        end else if (idm) begin
            r = (a == 16'h0000) ? 8'hDA : (a == 16'h0001) ? 8'hC8 : 8'h00;
        end else begin
            r = ad;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual oe/data=%h expected %h", req, act, exp);
        end
    endtask

    // One read: drive low, check result, release oe (ce stays low), check idle output.
    task automatic do_read(input string req, input logic [15:0] a, input logic [7:0] ad);
        logic [7:0] e;
        @(negedge clk);
        addr = a; arr_data = ad; ce_n = 1'b0; oe_n = 1'b0;
        e = exp_byte(busy, id_mode, a, last_addr, last_data, ad, tgl_m);
        @(negedge clk);
        check(req, {rd_oe, rd_data}, {1'b1, e});
        oe_n = 1'b1;
        @(negedge clk);
        if (busy) tgl_m = ~tgl_m;
        check("R1", {rd_oe, rd_data}, 9'h000);
        ce_n = 1'b1;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_fail++;
                $display("FAIL watchdog: actual cycles=%0d expected fewer", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check("R2", {rd_oe, rd_data}, 9'h000);
        rst = 1'b0;
        @(negedge clk);
        check("R2", {rd_oe, rd_data}, 9'h000);

        // array reads
        do_read("R8", 16'h1234, 8'h5A);
        do_read("R8", 16'hFFFF, 8'hA5);

        // identification
        id_mode = 1'b1;
        do_read("R7", 16'h0000, 8'h11);
        do_read("R7", 16'h0001, 8'h22);
        do_read("R7", 16'h0002, 8'h33);
        do_read("R7", 16'h8000, 8'h44);
        id_mode = 1'b0;

        // status: reset toggle is 0, verifies R2 toggle reset state
        last_addr = 16'h0420; last_data = 8'h80;
        busy = 1'b1;
        do_read("R3", 16'h0420, 8'hFF);
        do_read("R5", 16'h0420, 8'hFF);
        do_read("R4", 16'h0100, 8'hFF);
        last_data = 8'h7F;
        do_read("R3", 16'h0420, 8'h00);

        // deselected oe rise must not flip
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk); oe_n = 1'b1;
        @(negedge clk);
        do_read("R10", 16'h0420, 8'h00);

        // busy low: oe activity does not move toggle
        busy = 1'b0;
        do_read("R8", 16'h0420, 8'h3C);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); oe_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
        busy = 1'b1;
        do_read("R6", 16'h0420, 8'h00);

        // priority of busy over id
        id_mode = 1'b1;
        do_read("R9", 16'h0000, 8'h00);
        do_read("R9", 16'h0001, 8'h00);
        id_mode = 1'b0;
        busy = 1'b0;

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            int k;
            busy = $urandom_range(0, 2) == 0;
            id_mode = $urandom_range(0, 1);
            last_addr = $urandom();
            last_data = $urandom();
            k = $urandom_range(0, 3);
            a = (k == 0) ? 16'h0000 : (k == 1) ? 16'h0001 : (k == 2) ? last_addr : 16'($urandom());
            do_read(busy ? "R5" : (id_mode ? "R7" : "R8"), a, 8'($urandom()));
        end

        // synchronous reset clears toggle and output
        busy = 1'b1;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R2", {rd_oe, rd_data}, 9'h000);
        tgl_m = 1'b0;
        do_read("R2", 16'h0420, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule